// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request/acknowledge port and an asynchronous static RAM of 64K bytes. A single-cycle request carries a read/write flag, a 16-bit address and a byte of write data. The controller runs one complete memory cycle and then returns a one-cycle completion pulse. For a read, the captured byte is presented alongside that pulse. The memory is selected through two chip selects of opposite polarity, one active-low and one active-high. It is strobed with an active-low output enable and an active-low write enable. The bidirectional data bus is handled as separate outgoing data, incoming data and drive-enable signals.

The length of every phase is fixed at elaboration. The clock period in nanoseconds and the speed grade (55 or 70) are parameters. Each phase length is the nanosecond limit of that grade divided by the period, rounded up, with a floor of one cycle. A turnaround gap follows every cycle, so that the memory's output drivers have let go of the bus before the controller drives it or strobes the memory again. Requests that arrive while a cycle is in progress are dropped.

Top module: `sram_ctl`

## Requirements
- R1: While rst_n is low (sampled on the clock), mem_cs1_n=1, mem_cs2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0 and done=0.
- R2: mem_oe_n or mem_we_n is low only while mem_cs1_n=0 and mem_cs2=1. Between cycles, both chip selects are inactive (mem_cs1_n=1, mem_cs2=0).
- R3: A read holds mem_oe_n low and mem_we_n high, with the chip selected, for exactly RD_CYC = ceil(max(grade ns, OE access ns)/period) cycles (4 at 70 ns and 20 ns). rdata takes the mem_dq_in value present at the clock edge that ends the last of those cycles.
- R4: A write holds mem_we_n low for exactly WR_CYC = ceil(max(grade ns, WE pulse ns, address/select-to-end ns, data setup ns)/period) cycles (4 at the defaults). During those cycles mem_oe_n is high, mem_dq_oe is high, and mem_addr and mem_dq_out carry the requested address and byte. One further cycle follows with mem_we_n high, the chip still selected and the data still driven.
- R5: mem_dq_oe is never high while mem_oe_n is low. mem_dq_oe drops only while mem_we_n is high. The byte driven at the rising edge of mem_we_n is the byte stored.
- R6: done is high for exactly one cycle per accepted request. For a request sampled at clock edge k, done is high in the cycle after edge k+RD_CYC+1 for a read, and after edge k+WR_CYC+2 for a write.
- R7: A request is accepted only in the idle state. A request raised during a cycle produces no done pulse and no memory cycle.
- R8: After a cycle releases the bus (mem_oe_n rises or mem_dq_oe falls), at least TA_CYC+1 cycles pass before the next strobe or drive, where TA_CYC = ceil(25 ns/period) (2 at the defaults). A request presented in the first cycle that done allows is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request, sampled when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Request address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data from memory bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
Writes go to both ends of the address space, to a mid address and to an address with the top bit set. The stored bytes 0x00, 0xFF, 0xA5 and 0x5A are told apart from stuck or swapped data lines when they are read back. Reads of a location that was never written, and a write followed at once by a read of the same location, show whether the data is captured at the end of the read phase rather than from a stale bus value. Requests are issued back to back at the earliest allowed cycle, which pins down the exact done latency and turnaround. A request pushed into a busy cycle must leave both the memory contents and the count of done pulses unchanged.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state encoding and the nanosecond-to-cycle arithmetic
// used to size every phase. Assumes periods and limits are positive ns.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WHOLD,
        ST_TURN
    } seq_state_t;

    // Ceiling of ns over period, never less than one cycle.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Read phase: address access equals the grade; OE access is shorter.
    // Any grade other than 55 falls back to the slower limits.
    function automatic int read_ns(input int grade);
        int oe_acc;
        oe_acc = (grade == 55) ? 25 : 35;
        return max2((grade == 55) ? 55 : 70, oe_acc);
    endfunction

    // WE-low phase covers cycle time, pulse width, select/address to end
    // of write and data setup before WE rises.
    function automatic int write_ns(input int grade);
        int cyc_ns, pulse_ns, valid_ns, setup_ns;
        cyc_ns   = (grade == 55) ? 55 : 70;
        pulse_ns = (grade == 55) ? 40 : 55;
        valid_ns = (grade == 55) ? 45 : 60;
        setup_ns = (grade == 55) ? 20 : 30;
        return max2(max2(cyc_ns, pulse_ns), max2(valid_ns, setup_ns));
    endfunction

    localparam int TURN_NS = 25;

endpackage

// File: rtl/sram_ctl_timer.sv
// Phase timer: a loadable down-counter that flags when the current phase
// is in its last cycle. Assumes load values fit in CNT_W bits.
module sram_ctl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, reloading at each phase start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero count marks the final cycle of a phase.
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/sram_ctl_dpath.sv
// Datapath: latches the request address and write byte at acceptance and
// captures the bus byte at the end of a read. Holds values between cycles.
module sram_ctl_dpath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rdata
);

    // Latch address and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (cmd_load) begin
            mem_addr   <= addr;
            mem_dq_out <= wdata;
        end
    end

    // Register the memory byte at the end of the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= mem_dq_in;
        end
    end

endmodule

// File: rtl/sram_ctl_seq.sv
// Sequencer: walks idle -> read or write (+hold) -> turnaround -> idle and
// drives all memory strobes from flops. Assumes phase counts are >= 1.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int RD_CYC = 4,
    parameter int WR_CYC = 4,
    parameter int TA_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cmd_load,
    output logic             capture,
    output logic             cs1_n,
    output logic             cs2,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe,
    output logic             done
);

    seq_state_t state_q;
    logic       accept;

    // Decide acceptance, capture and timer reloads for this cycle.
    always_comb begin
        accept   = (state_q == ST_IDLE) && req;
        cmd_load = accept;
        capture  = (state_q == ST_READ) && tmr_expired;
        tmr_load = accept || capture || (state_q == ST_WHOLD);
        if (accept) begin
            tmr_val = wr ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end else begin
            tmr_val = CNT_W'(TA_CYC - 1);
        end
    end

    // Advance the cycle state and register every memory control pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs1_n   <= 1'b1;
            cs2     <= 1'b0;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            dq_oe   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        cs1_n <= 1'b0;
                        cs2   <= 1'b1;
                        if (wr) begin
                            we_n    <= 1'b0;
                            dq_oe   <= 1'b1;
                            state_q <= ST_WRITE;
                        end else begin
                            oe_n    <= 1'b0;
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (tmr_expired) begin
                        cs1_n   <= 1'b1;
                        cs2     <= 1'b0;
                        oe_n    <= 1'b1;
                        done    <= 1'b1;
                        state_q <= ST_TURN;
                    end
                end
                ST_WRITE: begin
                    if (tmr_expired) begin
                        we_n    <= 1'b1;
                        state_q <= ST_WHOLD;
                    end
                end
                ST_WHOLD: begin
                    cs1_n   <= 1'b1;
                    cs2     <= 1'b0;
                    dq_oe   <= 1'b0;
                    done    <= 1'b1;
                    state_q <= ST_TURN;
                end
                ST_TURN: begin
                    if (tmr_expired) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_ctl.sv
// Top: asynchronous SRAM cycle controller. Derives phase lengths from the
// clock period and speed grade, then wires timer, sequencer and datapath.
// Assumes the memory bus is resolved outside from mem_dq_out/mem_dq_oe.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int SPEED_GRADE   = 70,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int RD_CYC = ns_to_cyc(read_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int WR_CYC = ns_to_cyc(write_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int TA_CYC = ns_to_cyc(TURN_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC = max2(max2(RD_CYC, WR_CYC), TA_CYC);
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cmd_load;
    logic             capture;

    sram_ctl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctl_seq #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .wr          (wr),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cmd_load    (cmd_load),
        .capture     (capture),
        .cs1_n       (mem_cs1_n),
        .cs2         (mem_cs2),
        .oe_n        (mem_oe_n),
        .we_n        (mem_we_n),
        .dq_oe       (mem_dq_oe),
        .done        (done)
    );

    sram_ctl_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_load   (cmd_load),
        .capture    (capture),
        .addr       (addr),
        .wdata      (wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rdata      (rdata)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
// Checker: pin-level protocol properties of the controller, bound to the
// top module. Assumes rst_n is held low for at least two clocks at start.
module sram_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic mem_cs1_n,
    input logic mem_cs2,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe
);

    // R2: strobes only while both selects are active
    a_r2_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (!mem_cs1_n && mem_cs2));

    // R3: output enable never overlaps write enable
    a_r3_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    // R4: write enable low only with data driven
    a_r4_we_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R5: no drive while memory output is enabled
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5: drivers released only with write enable high
    a_r5_release_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> mem_we_n);

    // R6: completion pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: drive starts only after two bus-quiet cycles
    a_r8_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && !$past(mem_dq_oe, 2)));

endmodule

bind sram_ctl sram_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
// Scoreboard bench: driver task queues expected completions, a monitor at
// the falling edge pops and compares them and models the SRAM.
module sram_ctl_tb;

    localparam int PERIOD = 20;
    localparam int RD_CYC = (70 + PERIOD - 1) / PERIOD;
    localparam int WR_CYC = (70 + PERIOD - 1) / PERIOD;
    localparam int TA_CYC = (25 + PERIOD - 1) / PERIOD;

    typedef struct {
        bit          wr;
        logic [15:0] a;
        logic [7:0]  d;
        int          c;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        done;
    logic [15:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;
    item_t       q[$];
    logic [7:0]  sram_arr [logic [15:0]];
    logic [7:0]  ref_arr  [logic [15:0]];

    sram_ctl #(.CLK_PERIOD_NS(PERIOD), .SPEED_GRADE(70)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done(done), .mem_addr(mem_addr),
        .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", rq, cyc, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_rd(input logic [15:0] a);
        return ref_arr.exists(a) ? ref_arr[a] : 8'h00;
    endfunction

    // Queue one request at a falling edge; optionally push a stray request
    // into the busy window; wait until the earliest next accept point.
    task automatic issue(input bit w, input logic [15:0] a, input logic [7:0] d,
                         input bit intrude);
        item_t it;
        int    lat;
        it.wr = w; it.a = a; it.c = cyc;
        if (w) begin
            it.d = d; ref_arr[a] = d; lat = WR_CYC + 2;
        end else begin
            it.d = ref_rd(a); lat = RD_CYC + 1;
        end
        q.push_back(it);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0; addr = ~a; wdata = ~d;
        if (intrude) begin
            req = 1'b1; wr = 1'b1; addr = 16'h0BAD; wdata = 8'h77;
            @(negedge clk);
            @(negedge clk);
            req = 1'b0; wr = 1'b0;
            repeat (lat + TA_CYC - 3) @(negedge clk);
        end else begin
            repeat (lat + TA_CYC - 1) @(negedge clk);
        end
    endtask

    // Monitor and SRAM model state.
    logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_done = 1'b0;
    int   we_cnt = 0, oe_cnt = 0, rel_cyc = 0;
    bit   have_rel = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic bit sel = !mem_cs1_n && mem_cs2;
            automatic bit drv = sel && !mem_oe_n && mem_we_n;
            // R2: strobes need both selects
            if (!mem_oe_n || !mem_we_n)
                check(sel, "R2 strobe without select", {mem_cs1_n, mem_cs2}, 2'b01);
            // R5: no contention with memory output
            if (mem_dq_oe && drv) check(0, "R5 bus contention", 1, 0);
            // R4/R5: write lands at WE rise with data still driven
            if (!prev_we_n && mem_we_n) begin
                check(sel && mem_dq_oe, "R4 hold cycle keeps select and drive",
                      {sel, mem_dq_oe}, 2'b11);
                if (sel && mem_dq_oe) sram_arr[mem_addr] = mem_dq_out;
                check(we_cnt == WR_CYC, "R4 WE low length", we_cnt, WR_CYC);
                we_cnt = 0;
            end
            if (!mem_we_n) begin
                we_cnt++;
                if (q.size() > 0)
                    check(mem_oe_n && mem_dq_oe && mem_addr == q[0].a && mem_dq_out == q[0].d,
                          "R4 write pins", {mem_addr, mem_dq_out}, {q[0].a, q[0].d});
            end
            // R3: read strobe length
            if (!mem_oe_n) oe_cnt++;
            if (!prev_oe_n && mem_oe_n) begin
                check(oe_cnt == RD_CYC, "R3 OE low length", oe_cnt, RD_CYC);
                oe_cnt = 0; rel_cyc = cyc; have_rel = 1;
            end
            if (prev_dq_oe && !mem_dq_oe) begin
                rel_cyc = cyc; have_rel = 1;
            end
            // R8: turnaround before next strobe or drive
            if (have_rel && ((prev_oe_n && !mem_oe_n) || (!prev_dq_oe && mem_dq_oe)))
                check(cyc - rel_cyc >= TA_CYC + 1, "R8 turnaround gap", cyc - rel_cyc, TA_CYC + 1);
            // R6: single-cycle done
            if (prev_done && done) check(0, "R6 done longer than one cycle", 2, 1);
            // Scoreboard
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R7 done without accepted request", 1, 0);
                end else begin
                    automatic item_t it = q.pop_front();
                    automatic int lat = it.wr ? WR_CYC + 2 : RD_CYC + 1;
                    check(cyc == it.c + lat, "R6 done latency", cyc - it.c, lat);
                    if (!it.wr) check(rdata == it.d, "R3 read data", rdata, it.d);
                end
            end
            // Memory drives the bus for the coming edge
            mem_dq_in = drv ? (sram_arr.exists(mem_addr) ? sram_arr[mem_addr] : 8'h00) : 8'hEE;
            prev_we_n = mem_we_n; prev_oe_n = mem_oe_n;
            prev_dq_oe = mem_dq_oe; prev_done = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset pin state
        check(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe && !done,
              "R1 reset pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe, done},
              6'b101100);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs1_n && !mem_cs2, "R2 idle selects", {mem_cs1_n, mem_cs2}, 2'b10);

        issue(1'b1, 16'h0000, 8'hA5, 1'b0);
        issue(1'b1, 16'hFFFF, 8'h5A, 1'b0);
        issue(1'b1, 16'h1234, 8'h00, 1'b0);
        issue(1'b1, 16'h8001, 8'hFF, 1'b0);
        issue(1'b0, 16'h0000, 8'h00, 1'b0);
        issue(1'b0, 16'hFFFF, 8'h00, 1'b0);
        issue(1'b0, 16'h1234, 8'h00, 1'b0);
        issue(1'b0, 16'h8001, 8'h00, 1'b0);
        issue(1'b0, 16'h4444, 8'h00, 1'b0);
        issue(1'b1, 16'h4444, 8'h3C, 1'b0);
        issue(1'b0, 16'h4444, 8'h00, 1'b0);
        issue(1'b1, 16'h0000, 8'hC3, 1'b0);
        issue(1'b0, 16'h0000, 8'h00, 1'b0);
        // R7: stray write during a busy read must be dropped
        issue(1'b0, 16'hFFFF, 8'h00, 1'b1);
        issue(1'b1, 16'h0001, 8'h11, 1'b1);
        issue(1'b0, 16'h0BAD, 8'h00, 1'b0);
        issue(1'b0, 16'h0001, 8'h00, 1'b0);
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R7 every accepted request completed", q.size(), 0);
        check(!sram_arr.exists(16'h0BAD), "R7 stray write reached memory", 1, 0);
        check(mem_cs1_n && !mem_cs2 && !mem_dq_oe, "R2 selects released after traffic",
              {mem_cs1_n, mem_cs2, mem_dq_oe}, 3'b100);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule